// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel Sequencer

This block is the control sequencer for a single DMA channel. It does not move data itself. It works out what each transfer segment is and hands that segment to an external data mover. It then waits until the mover reports that the segment is finished.

The sequencer has two ways of starting:
- **Single-shot mode.** The four channel register values (device address, memory address, size word, link word) are taken directly as the only descriptor.
- **Chained mode.** The sequencer reads descriptors from memory through a word-wide read port that uses a request/grant handshake followed by a response. Each descriptor is four 32-bit words at consecutive addresses: device address, memory address, size word, link word. The first descriptor's address comes from the channel's link register.

The size word carries two fields: the element width code in bits [13:12] and the element count in bits [11:0]. The link word carries the chain control in bits [1:0]; its remaining upper bits hold the next descriptor's address. Bit 1 of the control selects whether the chain continues or ends. Bit 0 selects whether an interrupt is raised once the segment has finished. After each segment the sequencer either fetches the next descriptor, raises an interrupt, stops, or does more than one of these.

A two-bit state output tells software what the channel is doing:

| Value | Meaning |
|---|---|
| 0 | Idle |
| 1 | Reading a descriptor |
| 2 | Waiting for a read response |
| 3 | Handing off or running a segment |

Top module: `chain_seq`

## Requirements
- R1: After reset, `state_o` is 0 and `rd_req_o`, `seg_valid_o`, `irq_o` and `err_o` are all low.
- R2: A start pulse with `mode_i`=2 (single-shot) issues exactly one segment. The segment's device and memory addresses are the register values. The segment's width and count come from `reg_size_i`. No descriptor read is made.
- R3: Width code (size bits [13:12]) 3 gives `seg_width_o`=0 (1 byte), code 2 gives 1 (2 bytes) and code 0 gives 2 (4 bytes). `seg_count_o` is size bits [11:0].
- R4: A start with `mode_i`=1 (chained) reads four words. The first address is `reg_next_i` with bits [1:0] cleared, and the next three follow at +4, +8 and +12. The words are taken in the order device, memory, size, link. `state_o` is 1 while a request is outstanding and 2 while the sequencer waits for a response.
- R5: In chained mode, when link bit 1 is set the next descriptor is fetched from the link word with bits [1:0] cleared. When link bit 0 is set, `irq_o` pulses for one cycle in the cycle after the segment's `seg_done_i`.
- R6: When link bit 1 is clear, the channel returns to state 0 after the segment. It raises `irq_o` only if link bit 0 is set.
- R7: Width code 1, or a count above the width's limit (0x3FF for 1 and 2 bytes, 0x7FF for 4 bytes), is an error. On an error the chain ends with no segment issued, and `irq_o` and `err_o` pulse together.
- R8: A start pulse while the state is not 0 is ignored.
- R9: If `mode_i` is 0 when `seg_done_i` arrives, the channel goes idle. It makes no further read and raises no interrupt.
- R10: `rd_req_o` and `rd_addr_o` are held until `rd_gnt_i`. `seg_valid_o` and the segment fields are held until `seg_ready_i`.
- R11: `state_o` is 3 whenever `seg_valid_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Channel mode: 0 = off, 1 = chained, 2 = single-shot |
| start_i | input | 1 | Start pulse |
| reg_dev_i | input | 32 | Channel device-address register |
| reg_mem_i | input | 32 | Channel memory-address register |
| reg_size_i | input | 32 | Channel size register |
| reg_next_i | input | 32 | Channel link register |
| rd_req_o | output | 1 | Descriptor word read request |
| rd_addr_o | output | 32 | Descriptor word address |
| rd_gnt_i | input | 1 | Read request accepted |
| rd_valid_i | input | 1 | Read response valid |
| rd_data_i | input | 32 | Read response word |
| seg_valid_o | output | 1 | Segment offered to the data mover |
| seg_ready_i | input | 1 | Data mover accepts the segment |
| seg_done_i | input | 1 | Data mover has finished the segment |
| seg_dev_o | output | 32 | Segment device address |
| seg_mem_o | output | 32 | Segment memory address |
| seg_width_o | output | 2 | Element width as log2 of the byte count |
| seg_count_o | output | 12 | Element count |
| state_o | output | 2 | Channel state: 0 idle, 1 descriptor read, 2 wait, 3 access |
| irq_o | output | 1 | One-cycle interrupt pulse |
| err_o | output | 1 | One-cycle error pulse, always together with `irq_o` |

## Verification
Single-shot starts are run with every legal width code, and with counts at the width limits and one past them. This separates correct width and count decoding from a wrong limit or an error that goes undetected.

A three-descriptor chain has an unaligned start pointer and mixed control bits. It shows whether the address clearing, the word order, the follow decision and the interrupt selection are right, and it is run with stalled grants and stalled segment acceptance.

Further chains show three more behaviours:
- an error partway through the chain;
- an abort when the mode is dropped during a segment;
- a start pulse arriving while the channel is busy.

Together these show whether the sequencer stops at the right boundary, and whether it makes reads or issues segments that it should not.

// File: rtl/chain_seq_pkg.sv
package chain_seq_pkg;
  localparam int WORD_W = 32;
  localparam int CNT_W  = 12;

  localparam logic [1:0] MODE_OFF    = 2'd0;
  localparam logic [1:0] MODE_CHAIN  = 2'd1;
  localparam logic [1:0] MODE_SINGLE = 2'd2;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DREAD  = 2'd1,
    ST_WAIT   = 2'd2,
    ST_ACCESS = 2'd3
  } chan_state_e;

  // width code to log2(bytes)
  function automatic logic [1:0] width_of(input logic [1:0] code);
    case (code)
      2'd3:    return 2'd0;
      2'd2:    return 2'd1;
      default: return 2'd2;
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] count_limit(input logic [1:0] code);
    return (code == 2'd0) ? CNT_W'(12'h7FF) : CNT_W'(12'h3FF);
  endfunction

  function automatic logic [WORD_W-1:0] link_addr(input logic [WORD_W-1:0] w);
    return {w[WORD_W-1:2], 2'b00};
  endfunction
endpackage

// File: rtl/chain_seq_decode.sv
module chain_seq_decode
  import chain_seq_pkg::*;
(
  input  logic [WORD_W-1:0] size_i,
  output logic [1:0]        width_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              err_o
);
  logic [1:0] code;
  logic       unused_hi;

  assign code      = size_i[13:12];
  assign unused_hi = ^size_i[WORD_W-1:14];
  assign width_o   = width_of(code);
  assign count_o   = size_i[CNT_W-1:0];
  assign err_o     = (code == 2'd1) || (count_o > count_limit(code));
endmodule

// File: rtl/chain_seq_fetch.sv
module chain_seq_fetch
  import chain_seq_pkg::*;
#(
  parameter int NWORDS = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      go_i,
  input  logic [WORD_W-1:0]         base_i,
  output logic                      rd_req_o,
  output logic [WORD_W-1:0]         rd_addr_o,
  input  logic                      rd_gnt_i,
  input  logic                      rd_valid_i,
  input  logic [WORD_W-1:0]         rd_data_i,
  output logic                      word_we_o,
  output logic [$clog2(NWORDS)-1:0] word_idx_o,
  output logic [WORD_W-1:0]         word_o,
  output logic                      req_phase_o,
  output logic                      rsp_phase_o,
  output logic                      done_o
);
  localparam int IW = $clog2(NWORDS);

  typedef enum logic [1:0] {F_IDLE, F_REQ, F_RSP} fst_e;

  fst_e              fst;
  logic [IW-1:0]     idx;
  logic [WORD_W-1:0] base_q;
  logic              last;

  assign last        = (idx == IW'(NWORDS - 1));
  assign req_phase_o = (fst == F_REQ);
  assign rsp_phase_o = (fst == F_RSP);
  assign rd_req_o    = req_phase_o;
  assign rd_addr_o   = base_q + {{(WORD_W-IW-2){1'b0}}, idx, 2'b00};
  assign word_we_o   = rsp_phase_o && rd_valid_i;
  assign word_idx_o  = idx;
  assign word_o      = rd_data_i;
  assign done_o      = word_we_o && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fst    <= F_IDLE;
      idx    <= '0;
      base_q <= '0;
    end else begin
      case (fst)
        F_IDLE: if (go_i) begin
          fst    <= F_REQ;
          idx    <= '0;
          base_q <= base_i;
        end
        F_REQ:  if (rd_gnt_i) fst <= F_RSP;
        F_RSP:  if (rd_valid_i) begin
          if (last) fst <= F_IDLE;
          else begin
            fst <= F_REQ;
            idx <= idx + 1'b1;
          end
        end
        default: fst <= F_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/chain_seq.sv
module chain_seq
  import chain_seq_pkg::*;
#(
  parameter int DESC_WORDS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_i,
  input  logic              start_i,
  input  logic [WORD_W-1:0] reg_dev_i,
  input  logic [WORD_W-1:0] reg_mem_i,
  input  logic [WORD_W-1:0] reg_size_i,
  input  logic [WORD_W-1:0] reg_next_i,
  output logic              rd_req_o,
  output logic [WORD_W-1:0] rd_addr_o,
  input  logic              rd_gnt_i,
  input  logic              rd_valid_i,
  input  logic [WORD_W-1:0] rd_data_i,
  output logic              seg_valid_o,
  input  logic              seg_ready_i,
  input  logic              seg_done_i,
  output logic [WORD_W-1:0] seg_dev_o,
  output logic [WORD_W-1:0] seg_mem_o,
  output logic [1:0]        seg_width_o,
  output logic [CNT_W-1:0]  seg_count_o,
  output logic [1:0]        state_o,
  output logic              irq_o,
  output logic              err_o
);
  localparam int IW = $clog2(DESC_WORDS);

  typedef enum logic [2:0] {T_IDLE, T_FETCH, T_CHECK, T_ISSUE, T_RUN} tst_e;

  tst_e              tst;
  logic              chain_q, irq_q, err_q;
  logic [WORD_W-1:0] dsc [DESC_WORDS];

  // named internal events
  logic              start_ok, seg_end, abort_now, follow, fetch_go;
  logic [WORD_W-1:0] fetch_base;
  logic              f_we, f_req, f_rsp, f_done, dec_err;
  logic [IW-1:0]     f_idx;
  logic [WORD_W-1:0] f_word;

  assign start_ok   = (tst == T_IDLE) && start_i &&
                      (mode_i == MODE_CHAIN || mode_i == MODE_SINGLE);
  assign seg_end    = (tst == T_RUN) && seg_done_i;
  assign abort_now  = seg_end && (mode_i == MODE_OFF);
  assign follow     = seg_end && !abort_now && chain_q && dsc[3][1];
  assign fetch_go   = (start_ok && mode_i == MODE_CHAIN) || follow;
  assign fetch_base = follow ? link_addr(dsc[3]) : link_addr(reg_next_i);

  chain_seq_fetch #(.NWORDS(DESC_WORDS)) u_fetch (
    .clk(clk), .rst_n(rst_n), .go_i(fetch_go), .base_i(fetch_base),
    .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_gnt_i(rd_gnt_i),
    .rd_valid_i(rd_valid_i), .rd_data_i(rd_data_i),
    .word_we_o(f_we), .word_idx_o(f_idx), .word_o(f_word),
    .req_phase_o(f_req), .rsp_phase_o(f_rsp), .done_o(f_done)
  );

  chain_seq_decode u_dec (
    .size_i(dsc[2]), .width_o(seg_width_o), .count_o(seg_count_o), .err_o(dec_err)
  );

  assign seg_dev_o   = dsc[0];
  assign seg_mem_o   = dsc[1];
  assign seg_valid_o = (tst == T_ISSUE);
  assign irq_o       = irq_q;
  assign err_o       = err_q;

  always_comb begin
    case (tst)
      T_FETCH:       state_o = f_rsp ? ST_WAIT : ST_DREAD;
      T_CHECK:       state_o = ST_DREAD;
      T_ISSUE, T_RUN: state_o = ST_ACCESS;
      default:       state_o = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tst     <= T_IDLE;
      chain_q <= 1'b0;
      irq_q   <= 1'b0;
      err_q   <= 1'b0;
      for (int i = 0; i < DESC_WORDS; i++) dsc[i] <= '0;
    end else begin
      irq_q <= 1'b0;
      err_q <= 1'b0;
      if (tst == T_FETCH && f_we) dsc[f_idx] <= f_word;
      case (tst)
        T_IDLE: if (start_ok) begin
          chain_q <= (mode_i == MODE_CHAIN);
          if (mode_i == MODE_CHAIN) tst <= T_FETCH;
          else begin
            dsc[0] <= reg_dev_i;
            dsc[1] <= reg_mem_i;
            dsc[2] <= reg_size_i;
            dsc[3] <= reg_next_i;
            tst    <= T_CHECK;
          end
        end
        T_FETCH: if (f_done) tst <= T_CHECK;
        T_CHECK: if (dec_err) begin
          irq_q <= 1'b1;
          err_q <= 1'b1;
          tst   <= T_IDLE;
        end else tst <= T_ISSUE;
        T_ISSUE: if (seg_ready_i) tst <= T_RUN;
        T_RUN: if (seg_end) begin
          if (abort_now) tst <= T_IDLE;
          else begin
            irq_q <= dsc[3][0];
            tst   <= follow ? T_FETCH : T_IDLE;
          end
        end
        default: tst <= T_IDLE;
      endcase
    end
  end

  logic unused_req;
  assign unused_req = f_req;
endmodule

// File: rtl/chain_seq_chk.sv
module chain_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rd_req_o,
  input logic [31:0] rd_addr_o,
  input logic        rd_gnt_i,
  input logic        seg_valid_o,
  input logic        seg_ready_i,
  input logic [31:0] seg_dev_o,
  input logic [31:0] seg_mem_o,
  input logic [1:0]  seg_width_o,
  input logic [11:0] seg_count_o,
  input logic [1:0]  state_o,
  input logic        irq_o,
  input logic        err_o
);
  assert_seg_in_access_R11: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid_o |-> state_o == 2'd3);

  assert_req_in_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o |-> state_o == 2'd1);

  assert_req_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o |-> rd_addr_o[1:0] == 2'b00);

  assert_err_with_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> irq_o);

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o && !rd_gnt_i |=> rd_req_o && $stable(rd_addr_o));

  assert_seg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid_o && !seg_ready_i |=> seg_valid_o &&
      $stable({seg_dev_o, seg_mem_o, seg_width_o, seg_count_o}));

  assert_irq_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);

  assert_no_seg_on_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> !seg_valid_o && state_o != 2'd2);
endmodule

bind chain_seq chain_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
  .rd_gnt_i(rd_gnt_i), .seg_valid_o(seg_valid_o), .seg_ready_i(seg_ready_i),
  .seg_dev_o(seg_dev_o), .seg_mem_o(seg_mem_o), .seg_width_o(seg_width_o),
  .seg_count_o(seg_count_o), .state_o(state_o), .irq_o(irq_o), .err_o(err_o)
);

// File: tb/chain_seq_test.sv
module chain_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode_i = 2'd0;
  logic        start_i = 1'b0;
  logic [31:0] reg_dev_i = '0, reg_mem_i = '0, reg_size_i = '0, reg_next_i = '0;
  logic        rd_req_o, rd_gnt_i = 1'b0, rd_valid_i = 1'b0;
  logic [31:0] rd_addr_o, rd_data_i = '0;
  logic        seg_valid_o, seg_ready_i = 1'b0, seg_done_i = 1'b0;
  logic [31:0] seg_dev_o, seg_mem_o;
  logic [1:0]  seg_width_o, state_o;
  logic [11:0] seg_count_o;
  logic        irq_o, err_o;

  always #5 clk = ~clk;

  chain_seq uut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .start_i(start_i),
    .reg_dev_i(reg_dev_i), .reg_mem_i(reg_mem_i), .reg_size_i(reg_size_i),
    .reg_next_i(reg_next_i), .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
    .rd_gnt_i(rd_gnt_i), .rd_valid_i(rd_valid_i), .rd_data_i(rd_data_i),
    .seg_valid_o(seg_valid_o), .seg_ready_i(seg_ready_i), .seg_done_i(seg_done_i),
    .seg_dev_o(seg_dev_o), .seg_mem_o(seg_mem_o), .seg_width_o(seg_width_o),
    .seg_count_o(seg_count_o), .state_o(state_o), .irq_o(irq_o), .err_o(err_o)
  );

  int checks = 0, fails = 0;
  int seg_cnt = 0, irq_cnt = 0, err_cnt = 0, rd_cnt = 0;
  int gnt_dly = 0, rdy_dly = 0;
  logic [31:0] mem [64];
  logic [77:0] exp_seg [$];
  logic [31:0] exp_addr [$];

  task automatic chk(input bit ok, input string req, input logic [77:0] act, input logic [77:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_width(input logic [1:0] code);
    if (code == 2'd3) return 2'd0;
    if (code == 2'd2) return 2'd1;
    return 2'd2;
  endfunction

  task automatic push_seg(input logic [31:0] dev, input logic [31:0] memad, input logic [31:0] size);
    exp_seg.push_back({dev, memad, exp_width(size[13:12]), size[11:0]});
  endtask

  task automatic push_reads(input logic [31:0] base);
    for (int k = 0; k < 4; k++) exp_addr.push_back(base + 32'(4 * k));
  endtask

  task automatic put_desc(input logic [31:0] a, input logic [31:0] d, input logic [31:0] m,
                          input logic [31:0] s, input logic [31:0] n);
    mem[a[7:2]] = d; mem[a[7:2] + 6'd1] = m; mem[a[7:2] + 6'd2] = s; mem[a[7:2] + 6'd3] = n;
  endtask

  // memory responder
  always begin
    @(negedge clk);
    if (rd_req_o) begin
      logic [31:0] a;
      a = rd_addr_o;
      chk(state_o == 2'd1, "R4 state during request", 78'(state_o), 78'd1);
      if (exp_addr.size() == 0) chk(1'b0, "R4 unexpected read", 78'(a), 78'd0);
      else begin
        logic [31:0] e;
        e = exp_addr.pop_front();
        chk(a == e, "R4 read address", 78'(a), 78'(e));
      end
      for (int k = 0; k < gnt_dly; k++) begin
        @(negedge clk);
        chk(rd_req_o && rd_addr_o == a, "R10 request held", 78'(rd_addr_o), 78'(a));
      end
      rd_cnt++;
      rd_gnt_i = 1'b1;
      @(negedge clk);
      rd_gnt_i = 1'b0;
      chk(state_o == 2'd2, "R4 state during wait", 78'(state_o), 78'd2);
      rd_data_i  = mem[a[7:2]];
      rd_valid_i = 1'b1;
      @(negedge clk);
      rd_valid_i = 1'b0;
    end
  end

  // data mover and scoreboard monitor
  always begin
    @(negedge clk);
    if (seg_valid_o) begin
      logic [77:0] act;
      chk(state_o == 2'd3, "R11 state during segment", 78'(state_o), 78'd3);
      act = {seg_dev_o, seg_mem_o, seg_width_o, seg_count_o};
      for (int k = 0; k < rdy_dly; k++) begin
        @(negedge clk);
        chk(seg_valid_o && {seg_dev_o, seg_mem_o, seg_width_o, seg_count_o} == act,
            "R10 segment held", {seg_dev_o, seg_mem_o, seg_width_o, seg_count_o}, act);
      end
      if (exp_seg.size() == 0) chk(1'b0, "R2 unexpected segment", act, 78'd0);
      else begin
        logic [77:0] e;
        e = exp_seg.pop_front();
        chk(act == e, "R3 segment fields", act, e);
      end
      seg_cnt++;
      seg_ready_i = 1'b1;
      @(negedge clk);
      seg_ready_i = 1'b0;
      repeat (3) @(negedge clk);
      seg_done_i = 1'b1;
      @(negedge clk);
      seg_done_i = 1'b0;
    end
  end

  always @(negedge clk) begin
    if (irq_o) irq_cnt++;
    if (err_o) err_cnt++;
  end

  task automatic pulse_start(input logic [1:0] m);
    @(negedge clk);
    mode_i  = m;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 3000; k++) begin
      if (state_o == 2'd0) break;
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic set_regs(input logic [31:0] d, input logic [31:0] m, input logic [31:0] s, input logic [31:0] n);
    reg_dev_i = d; reg_mem_i = m; reg_size_i = s; reg_next_i = n;
  endtask

  task automatic expect_counts(input string req, input int s0, input int i0, input int e0, input int r0,
                               input int ds, input int di, input int de, input int dr);
    chk(seg_cnt - s0 == ds, {req, " segment count"}, 78'(seg_cnt - s0), 78'(ds));
    chk(irq_cnt - i0 == di, {req, " irq count"}, 78'(irq_cnt - i0), 78'(di));
    chk(err_cnt - e0 == de, {req, " err count"}, 78'(err_cnt - e0), 78'(de));
    chk(rd_cnt - r0 == dr, {req, " read count"}, 78'(rd_cnt - r0), 78'(dr));
  endtask

  task automatic single(input string req, input logic [31:0] s, input logic [31:0] n,
                        input bit good, input int di, input int de);
    int s0, i0, e0, r0;
    s0 = seg_cnt; i0 = irq_cnt; e0 = err_cnt; r0 = rd_cnt;
    set_regs(32'hD000_0100, 32'h8000_0040, s, n);
    if (good) push_seg(32'hD000_0100, 32'h8000_0040, s);
    pulse_start(2'd2);
    wait_idle();
    expect_counts(req, s0, i0, e0, r0, good ? 1 : 0, di, de, 0);
    chk(state_o == 2'd0, {req, " idle after"}, 78'(state_o), 78'd0);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    int s0, i0, e0, r0;
    for (int k = 0; k < 64; k++) mem[k] = '0;
    repeat (3) @(negedge clk);
    chk(state_o == 2'd0, "R1 reset state", 78'(state_o), 78'd0);
    chk({rd_req_o, seg_valid_o, irq_o, err_o} == 4'b0, "R1 reset outputs",
        78'({rd_req_o, seg_valid_o, irq_o, err_o}), 78'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // single-shot, every legal width and the limits
    single("R2 4B max with irq", {18'd0, 2'd0, 12'h7FF}, 32'h1, 1'b1, 1, 0);
    single("R6 1B max no irq",   {18'd0, 2'd3, 12'h3FF}, 32'h0, 1'b1, 0, 0);
    single("R3 2B with irq",     {18'd0, 2'd2, 12'h123}, 32'h1, 1'b1, 1, 0);
    single("R7 2B over limit",   {18'd0, 2'd2, 12'h400}, 32'h0, 1'b0, 1, 1);
    single("R7 4B over limit",   {18'd0, 2'd0, 12'h800}, 32'h0, 1'b0, 1, 1);
    single("R7 width code one",  {18'd0, 2'd1, 12'h005}, 32'h0, 1'b0, 1, 1);

    // three-descriptor chain, stalls on both handshakes
    gnt_dly = 2; rdy_dly = 2;
    put_desc(32'h10, 32'hA1, 32'hB1, {18'd0, 2'd0, 12'h010}, 32'h40 | 32'h3);
    put_desc(32'h40, 32'hA2, 32'hB2, {18'd0, 2'd3, 12'h020}, 32'h80 | 32'h2);
    put_desc(32'h80, 32'hA3, 32'hB3, {18'd0, 2'd2, 12'h030}, 32'h0  | 32'h1);
    push_reads(32'h10); push_reads(32'h40); push_reads(32'h80);
    push_seg(32'hA1, 32'hB1, {18'd0, 2'd0, 12'h010});
    push_seg(32'hA2, 32'hB2, {18'd0, 2'd3, 12'h020});
    push_seg(32'hA3, 32'hB3, {18'd0, 2'd2, 12'h030});
    s0 = seg_cnt; i0 = irq_cnt; e0 = err_cnt; r0 = rd_cnt;
    set_regs(32'h0, 32'h0, 32'h0, 32'h13);
    pulse_start(2'd1);
    wait_idle();
    expect_counts("R5 chain of three", s0, i0, e0, r0, 3, 2, 0, 12);
    gnt_dly = 0; rdy_dly = 0;

    // error in second descriptor
    put_desc(32'h20, 32'hC1, 32'hE1, {18'd0, 2'd3, 12'h001}, 32'h30 | 32'h2);
    put_desc(32'h30, 32'hC2, 32'hE2, {18'd0, 2'd1, 12'h001}, 32'h0);
    push_reads(32'h20); push_reads(32'h30);
    push_seg(32'hC1, 32'hE1, {18'd0, 2'd3, 12'h001});
    s0 = seg_cnt; i0 = irq_cnt; e0 = err_cnt; r0 = rd_cnt;
    set_regs(32'h0, 32'h0, 32'h0, 32'h20);
    pulse_start(2'd1);
    wait_idle();
    expect_counts("R7 chain error", s0, i0, e0, r0, 1, 1, 1, 8);

    // abort by dropping the mode during the first segment
    put_desc(32'h60, 32'hF1, 32'h91, {18'd0, 2'd0, 12'h004}, 32'hC0 | 32'h3);
    put_desc(32'hC0, 32'hF2, 32'h92, {18'd0, 2'd0, 12'h004}, 32'h1);
    push_reads(32'h60);
    push_seg(32'hF1, 32'h91, {18'd0, 2'd0, 12'h004});
    s0 = seg_cnt; i0 = irq_cnt; e0 = err_cnt; r0 = rd_cnt;
    set_regs(32'h0, 32'h0, 32'h0, 32'h60);
    pulse_start(2'd1);
    for (int k = 0; k < 500 && seg_cnt == s0; k++) @(negedge clk);
    mode_i = 2'd0;
    wait_idle();
    repeat (10) @(negedge clk);
    expect_counts("R9 abort", s0, i0, e0, r0, 1, 0, 0, 4);
    chk(state_o == 2'd0, "R9 idle after abort", 78'(state_o), 78'd0);

    // start pulse while busy is ignored
    push_reads(32'h10); push_reads(32'h40); push_reads(32'h80);
    push_seg(32'hA1, 32'hB1, {18'd0, 2'd0, 12'h010});
    push_seg(32'hA2, 32'hB2, {18'd0, 2'd3, 12'h020});
    push_seg(32'hA3, 32'hB3, {18'd0, 2'd2, 12'h030});
    s0 = seg_cnt; i0 = irq_cnt; e0 = err_cnt; r0 = rd_cnt;
    set_regs(32'h0, 32'h0, 32'h0, 32'h10);
    pulse_start(2'd1);
    for (int k = 0; k < 500 && seg_cnt == s0; k++) @(negedge clk);
    set_regs(32'h5555_0000, 32'h6666_0000, {18'd0, 2'd0, 12'h001}, 32'h0);
    pulse_start(2'd2);
    wait_idle();
    expect_counts("R8 start while busy", s0, i0, e0, r0, 3, 2, 0, 12);

    chk(exp_seg.size() == 0, "R2 segments left over", 78'(exp_seg.size()), 78'd0);
    chk(exp_addr.size() == 0, "R4 reads left over", 78'(exp_addr.size()), 78'd0);
    report();
  end
endmodule